// File: doc/BRIEF.md
# Serial Command Decoder and Register File

This block sits behind a serial port shifter. It takes 16-bit words that have already been assembled and decodes each one as a command. It also keeps a small register file for configuration and calibration. Six commands have fixed codes. The other two kinds of command, register read and register write, carry a starting address and a word count. Reads stream one response word per cycle. Writes take their data from the word strobes that follow the command. A lock command freezes the configuration until an unlock command arrives.

A status word collects sticky fault flags from event inputs elsewhere on the chip. These flags are cleared only when software reads the status. The status word also holds a reset indicator. That indicator can be cleared only by writing zero to the matching bit of the mode register. Three pulse outputs tell the surrounding logic that a soft reset, standby or wakeup was requested. Serial shifting and CRC computation are done outside this block.

Top module: `spi_cmd_regfile`

## Requirements
- R1: After reset the registers read as follows: status 0540h, mode (address 02h) 0510h, clock (03h) 030Eh, gain (04h) 0000h, config (06h) 0600h, every channel gain-calibration upper word (channel base 09h + 5·ch, offset 3) 8000h, and identity (00h) 2200h.
- R2: The NULL word 0000h returns the status word on respWord with respValid in the cycle after the strobe. In the same edge it clears the sticky flags: bit 14 resync, bit 13 map-CRC, bit 12 input-CRC, bit 7 memory fault and bit 6 supply fault.
- R3: A read word has bits 15:13 = 101, bits 12:7 = start address and bits 6:0 = count minus one. It returns count words from consecutive addresses, one per cycle, starting two cycles after the strobe. Unimplemented addresses read 0000h. Words strobed while the stream runs are dropped.
- R4: A read whose range covers address 01h clears the sticky flags.
- R5: A write word has bits 15:13 = 011 and the same address and count fields. The next count strobed words are written to consecutive addresses. Writes to unimplemented or read-only addresses are discarded.
- R6: Reserved bits read as zero whatever is written. The writable masks are: mode 3F1Fh, clock 03FFh, gain 0077h, config 7F00h, supply control (31h) 0F01h, channel config FFC3h, and calibration lower words FF00h.
- R7: LOCK (0555h) sets status bit 15. UNLOCK (0655h) clears it.
- R8: While locked, only NULL, UNLOCK and reads starting at 01h are acted on. Every other word has no effect.
- R9: Each event input sets its sticky flag one cycle later. If an event and a clear happen in the same cycle, the event wins.
- R10: The memory-fault input is a level. While it is held, its flag sets again in the cycle after a clear.
- R11: Status bit 10 is set by power-on reset and by the RESET command. It is cleared only by a write to the mode register with bit 10 = 0.
- R12: RESET (0011h) pulses resetOut for one cycle and returns every register to its reset value.
- R13: STANDBY (0022h) and WAKEUP (0033h) each pulse their own output for one cycle, the cycle after the strobe. At most one of the three pulse outputs is high at a time.
- R14: Status bit 11 and bits 9:8 mirror bit 11 and bits 9:8 of the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wordValid | input | 1 | Strobe for a received word |
| word | input | 16 | Received command or data word |
| evResync | input | 1 | Resynchronization event pulse |
| evRegCrc | input | 1 | Register-map CRC fault pulse |
| evCrcErr | input | 1 | Input CRC error pulse |
| memFault | input | 1 | Memory fault level |
| evSupply | input | 1 | Supply fault pulse |
| respValid | output | 1 | Response word valid |
| respWord | output | 16 | Response word |
| statusWord | output | 16 | Current status word |
| modeWord | output | 16 | Mode register |
| clockWord | output | 16 | Clock register |
| gainWord | output | 16 | Gain register |
| cfgWord | output | 16 | Config register |
| dcdcWord | output | 16 | Supply control register |
| chanFlat | output | 160 | Channel registers; word ch·5+k at bits 16·(ch·5+k) upward |
| resetOut | output | 1 | Soft reset request pulse |
| standbyOut | output | 1 | Standby request pulse |
| wakeupOut | output | 1 | Wakeup request pulse |

## Verification
The hardest cases to reach from the ports depend on exact cycle alignment. One is an event pulse that lands in the same edge as a status clear. The other is a word that arrives while a read stream is still running. The stimulus drives an event pulse and the NULL strobe on the same negative edge. It also holds the memory-fault level high across a clear. It then strobes a LOCK word in the first streaming cycle of a three-word read and shows that the lock bit stays low.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int CNT_W = 7;
  localparam int CH_STRIDE = 5;
  localparam int NUM_COMMON = 5;

  localparam logic [ADDR_W-1:0] ADDR_ID = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h01;
  localparam logic [ADDR_W-1:0] CH_BASE = 6'h09;

  localparam logic [DATA_W-1:0] CMD_NULL = 16'h0000;
  localparam logic [DATA_W-1:0] CMD_RESET = 16'h0011;
  localparam logic [DATA_W-1:0] CMD_STANDBY = 16'h0022;
  localparam logic [DATA_W-1:0] CMD_WAKEUP = 16'h0033;
  localparam logic [DATA_W-1:0] CMD_LOCK = 16'h0555;
  localparam logic [DATA_W-1:0] CMD_UNLOCK = 16'h0655;
  localparam logic [2:0] PFX_RD = 3'b101;
  localparam logic [2:0] PFX_WR = 3'b011;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} scr_state_t;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
    logic              statClr;
    logic              softRst;
  } ctrl_strb_t;

  // common register slots: 0 mode, 1 clock, 2 gain, 3 config, 4 supply control
  function automatic logic [ADDR_W-1:0] commonAddr(input int i);
    case (i)
      0: return 6'h02;
      1: return 6'h03;
      2: return 6'h04;
      3: return 6'h06;
      default: return 6'h31;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] commonMask(input int i);
    case (i)
      0: return 16'h3F1F;
      1: return 16'h03FF;
      2: return 16'h0077;
      3: return 16'h7F00;
      default: return 16'h0F01;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] commonRst(input int i);
    case (i)
      0: return 16'h0510;
      1: return 16'h030E;
      3: return 16'h0600;
      default: return 16'h0000;
    endcase
  endfunction

  // channel slot k: 0 config, 1 offset upper, 2 offset lower, 3 gain upper, 4 gain lower
  function automatic logic [DATA_W-1:0] chanMask(input int k);
    case (k)
      0: return 16'hFFC3;
      2, 4: return 16'hFF00;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] chanRst(input int k);
    return (k == 3) ? 16'h8000 : 16'h0000;
  endfunction
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] rdData,
  output ctrl_strb_t        strb,
  output logic              locked,
  output logic              idle,
  output logic              respValid,
  output logic [DATA_W-1:0] respWord,
  output logic              resetOut,
  output logic              standbyOut,
  output logic              wakeupOut
);
  scr_state_t state;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0] left;

  logic isNull, isReset, isStandby, isWakeup, isLock, isUnlock, opRd, opWr, accept;
  logic [ADDR_W-1:0] cmdAddr;
  logic [CNT_W-1:0] cmdCnt;

  always_comb begin
    idle      = (state == ST_IDLE);
    isNull    = (word == CMD_NULL);
    isReset   = (word == CMD_RESET);
    isStandby = (word == CMD_STANDBY);
    isWakeup  = (word == CMD_WAKEUP);
    isLock    = (word == CMD_LOCK);
    isUnlock  = (word == CMD_UNLOCK);
    opRd      = (word[DATA_W-1 -: 3] == PFX_RD);
    opWr      = (word[DATA_W-1 -: 3] == PFX_WR);
    cmdAddr   = word[CNT_W +: ADDR_W];
    cmdCnt    = word[CNT_W-1:0];
    accept    = idle && wordValid &&
                (!locked || isNull || isUnlock || (opRd && cmdAddr == ADDR_STATUS));

    strb.wrEn    = (state == ST_WRITE) && wordValid;
    strb.wrAddr  = ptr;
    strb.wrData  = word;
    strb.rdAddr  = (state == ST_READ) ? ptr : ADDR_STATUS;
    strb.statClr = (accept && isNull) || ((state == ST_READ) && ptr == ADDR_STATUS);
    strb.softRst = accept && isReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      left       <= '0;
      locked     <= 1'b0;
      respValid  <= 1'b0;
      respWord   <= '0;
      resetOut   <= 1'b0;
      standbyOut <= 1'b0;
      wakeupOut  <= 1'b0;
    end else begin
      respValid  <= 1'b0;
      resetOut   <= 1'b0;
      standbyOut <= 1'b0;
      wakeupOut  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (isNull) begin
            respValid <= 1'b1;
            respWord  <= rdData;
          end
          if (isReset) begin
            resetOut <= 1'b1;
            locked   <= 1'b0;
          end
          if (isStandby) standbyOut <= 1'b1;
          if (isWakeup)  wakeupOut  <= 1'b1;
          if (isLock)    locked     <= 1'b1;
          if (isUnlock)  locked     <= 1'b0;
          if (opRd || opWr) begin
            ptr   <= cmdAddr;
            left  <= cmdCnt;
            state <= opRd ? ST_READ : ST_WRITE;
          end
        end
        ST_READ: begin
          respValid <= 1'b1;
          respWord  <= rdData;
          ptr       <= ptr + 1'b1;
          if (left == '0) state <= ST_IDLE;
          else            left  <= left - 1'b1;
        end
        default: if (wordValid) begin
          ptr <= ptr + 1'b1;
          if (left == '0) state <= ST_IDLE;
          else            left  <= left - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrl_strb_t                         strb,
  input  logic                               locked,
  input  logic                               evResync,
  input  logic                               evRegCrc,
  input  logic                               evCrcErr,
  input  logic                               memFault,
  input  logic                               evSupply,
  output logic [DATA_W-1:0]                  rdData,
  output logic [DATA_W-1:0]                  statusWord,
  output logic [NUM_COMMON*DATA_W-1:0]       commonFlat,
  output logic [NUM_CH*CH_STRIDE*DATA_W-1:0] chanFlat
);
  localparam int NCR = NUM_CH * CH_STRIDE;
  localparam logic [DATA_W-1:0] ID_WORD = {4'b0010, 4'(NUM_CH), 8'h00};

  logic [DATA_W-1:0] comReg [NUM_COMMON];
  logic [DATA_W-1:0] chReg [NCR];
  logic fResync, fRegCrc, fCrcErr, fMem, fSupply, fReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_COMMON; i++) comReg[i] <= commonRst(i);
      for (int j = 0; j < NCR; j++) chReg[j] <= chanRst(j % CH_STRIDE);
      fResync <= 1'b0;
      fRegCrc <= 1'b0;
      fCrcErr <= 1'b0;
      fMem    <= 1'b0;
      fSupply <= 1'b1;
      fReset  <= 1'b1;
    end else if (strb.softRst) begin
      for (int i = 0; i < NUM_COMMON; i++) comReg[i] <= commonRst(i);
      for (int j = 0; j < NCR; j++) chReg[j] <= chanRst(j % CH_STRIDE);
      fResync <= evResync;
      fRegCrc <= evRegCrc;
      fCrcErr <= evCrcErr;
      fMem    <= memFault;
      fSupply <= 1'b1;
      fReset  <= 1'b1;
    end else begin
      for (int i = 0; i < NUM_COMMON; i++)
        if (strb.wrEn && strb.wrAddr == commonAddr(i))
          comReg[i] <= strb.wrData & commonMask(i);
      for (int j = 0; j < NCR; j++)
        if (strb.wrEn && strb.wrAddr == ADDR_W'(CH_BASE + j))
          chReg[j] <= strb.wrData & chanMask(j % CH_STRIDE);
      fResync <= (fResync & ~strb.statClr) | evResync;
      fRegCrc <= (fRegCrc & ~strb.statClr) | evRegCrc;
      fCrcErr <= (fCrcErr & ~strb.statClr) | evCrcErr;
      fMem    <= (fMem & ~strb.statClr) | memFault;
      fSupply <= (fSupply & ~strb.statClr) | evSupply;
      if (strb.wrEn && strb.wrAddr == commonAddr(0) && !strb.wrData[10])
        fReset <= 1'b0;
    end
  end

  always_comb begin
    statusWord = {locked, fResync, fRegCrc, fCrcErr, comReg[0][11], fReset,
                  comReg[0][9:8], fMem, fSupply, 6'b000000};
    rdData = '0;
    if (strb.rdAddr == ADDR_ID) rdData = ID_WORD;
    if (strb.rdAddr == ADDR_STATUS) rdData = statusWord;
    for (int i = 0; i < NUM_COMMON; i++)
      if (strb.rdAddr == commonAddr(i)) rdData = comReg[i];
    for (int j = 0; j < NCR; j++)
      if (strb.rdAddr == ADDR_W'(CH_BASE + j)) rdData = chReg[j];
  end

  for (genvar gi = 0; gi < NUM_COMMON; gi++) begin : g_com
    assign commonFlat[gi*DATA_W +: DATA_W] = comReg[gi];
  end
  for (genvar gj = 0; gj < NCR; gj++) begin : g_chan
    assign chanFlat[gj*DATA_W +: DATA_W] = chReg[gj];
  end
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
  import scr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wordValid,
  input  logic [15:0]                        word,
  input  logic                               evResync,
  input  logic                               evRegCrc,
  input  logic                               evCrcErr,
  input  logic                               memFault,
  input  logic                               evSupply,
  output logic                               respValid,
  output logic [15:0]                        respWord,
  output logic [15:0]                        statusWord,
  output logic [15:0]                        modeWord,
  output logic [15:0]                        clockWord,
  output logic [15:0]                        gainWord,
  output logic [15:0]                        cfgWord,
  output logic [15:0]                        dcdcWord,
  output logic [NUM_CH*CH_STRIDE*16-1:0]     chanFlat,
  output logic                               resetOut,
  output logic                               standbyOut,
  output logic                               wakeupOut
);
  ctrl_strb_t strb;
  logic locked, idle;
  logic [DATA_W-1:0] rdData;
  logic [NUM_COMMON*DATA_W-1:0] commonFlat;

  scr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .word(word), .rdData(rdData),
    .strb(strb), .locked(locked), .idle(idle), .respValid(respValid),
    .respWord(respWord), .resetOut(resetOut), .standbyOut(standbyOut),
    .wakeupOut(wakeupOut)
  );

  scr_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .locked(locked), .evResync(evResync),
    .evRegCrc(evRegCrc), .evCrcErr(evCrcErr), .memFault(memFault),
    .evSupply(evSupply), .rdData(rdData), .statusWord(statusWord),
    .commonFlat(commonFlat), .chanFlat(chanFlat)
  );

  assign modeWord  = commonFlat[0*DATA_W +: DATA_W];
  assign clockWord = commonFlat[1*DATA_W +: DATA_W];
  assign gainWord  = commonFlat[2*DATA_W +: DATA_W];
  assign cfgWord   = commonFlat[3*DATA_W +: DATA_W];
  assign dcdcWord  = commonFlat[4*DATA_W +: DATA_W];
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        idle,
  input logic        wordValid,
  input logic [15:0] word,
  input logic        respValid,
  input logic [15:0] respWord,
  input logic [15:0] statusWord,
  input logic [15:0] modeWord,
  input logic [15:0] clockWord,
  input logic        evResync,
  input logic        memFault,
  input logic        resetOut,
  input logic        standbyOut,
  input logic        wakeupOut
);
  p_null_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && wordValid && word == 16'h0000) |=> (respValid && respWord == $past(statusWord)));

  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (idle && wordValid && word == 16'h0555) |=> statusWord[15]);

  p_unlock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (idle && wordValid && word == 16'h0655) |=> !statusWord[15]);

  p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[15] |=> ($stable(modeWord) && $stable(clockWord)));

  p_resync_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    evResync |=> statusWord[14]);

  p_memfault_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    memFault |=> statusWord[7]);

  p_reset_flag_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[10]) |-> resetOut);

  p_pulse_excl_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetOut, standbyOut, wakeupOut}));
endmodule

bind spi_cmd_regfile scr_checker u_chk (
  .clk(clk), .rstN(rstN), .idle(idle), .wordValid(wordValid), .word(word),
  .respValid(respValid), .respWord(respWord), .statusWord(statusWord),
  .modeWord(modeWord), .clockWord(clockWord), .evResync(evResync),
  .memFault(memFault), .resetOut(resetOut), .standbyOut(standbyOut),
  .wakeupOut(wakeupOut)
);

// File: tb/tb_spi_cmd_regfile.sv
module tb_spi_cmd_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [15:0] word = '0;
  logic evResync = 1'b0, evRegCrc = 1'b0, evCrcErr = 1'b0, memFault = 1'b0, evSupply = 1'b0;
  logic respValid, resetOut, standbyOut, wakeupOut;
  logic [15:0] respWord, statusWord, modeWord, clockWord, gainWord, cfgWord, dcdcWord;
  logic [159:0] chanFlat;

  int checks = 0;
  int fails = 0;
  int rstCnt = 0, sbyCnt = 0, wakCnt = 0;

  always #5 clk = ~clk;

  spi_cmd_regfile dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .word(word), .evResync(evResync),
    .evRegCrc(evRegCrc), .evCrcErr(evCrcErr), .memFault(memFault), .evSupply(evSupply),
    .respValid(respValid), .respWord(respWord), .statusWord(statusWord),
    .modeWord(modeWord), .clockWord(clockWord), .gainWord(gainWord), .cfgWord(cfgWord),
    .dcdcWord(dcdcWord), .chanFlat(chanFlat), .resetOut(resetOut),
    .standbyOut(standbyOut), .wakeupOut(wakeupOut)
  );

  always @(posedge clk) begin
    if (resetOut) rstCnt++;
    if (standbyOut) sbyCnt++;
    if (wakeupOut) wakCnt++;
  end

  // entries: {address, written word, expected read-back}
  localparam logic [47:0] VEC [14] = '{
    {16'h0002, 16'hFFFF, 16'h3F1F}, {16'h0003, 16'hFFFF, 16'h03FF},
    {16'h0004, 16'hFFFF, 16'h0077}, {16'h0006, 16'hFFFF, 16'h7F00},
    {16'h0009, 16'hFFFF, 16'hFFC3}, {16'h000A, 16'h1234, 16'h1234},
    {16'h000B, 16'hABCD, 16'hAB00}, {16'h000C, 16'h0000, 16'h0000},
    {16'h000E, 16'h003C, 16'h0000}, {16'h0031, 16'hFFFF, 16'h0F01},
    {16'h0005, 16'hFFFF, 16'h0000}, {16'h003E, 16'hFFFF, 16'h0000},
    {16'h0000, 16'hFFFF, 16'h2200}, {16'h0012, 16'h5A5A, 16'h5A00}
  };

  function automatic logic [15:0] mkCmd(input logic [2:0] pfx, input logic [5:0] a,
                                        input logic [6:0] n);
    return {pfx, a, n};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    word = w;
    @(negedge clk);
    wordValid = 1'b0;
    word = '0;
  endtask

  task automatic readOne(input logic [5:0] a, output logic [15:0] v, output logic vld);
    sendWord(mkCmd(3'b101, a, 7'd0));
    @(negedge clk);
    v = respWord;
    vld = respValid;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] v;
    logic vld;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    check("R1 status", statusWord, 16'h0540);
    check("R1 mode", modeWord, 16'h0510);
    check("R1 clock", clockWord, 16'h030E);
    check("R1 gain", gainWord, 16'h0000);
    check("R1 config", cfgWord, 16'h0600);
    check("R1 ch0 gain upper", chanFlat[63:48], 16'h8000);
    check("R1 ch1 gain upper", chanFlat[143:128], 16'h8000);
    readOne(6'h00, v, vld);
    check("R1 identity", v, 16'h2200);

    // R3 three-word stream, a LOCK strobed mid-stream is dropped
    @(negedge clk);
    wordValid = 1'b1;
    word = mkCmd(3'b101, 6'h02, 7'd2);
    @(negedge clk);
    word = 16'h0555;
    @(negedge clk);
    wordValid = 1'b0;
    word = '0;
    check("R3 word0", respWord, 16'h0510);
    check("R3 valid0", {15'd0, respValid}, 16'h0001);
    @(negedge clk);
    check("R3 word1", respWord, 16'h030E);
    @(negedge clk);
    check("R3 word2", respWord, 16'h0000);
    @(negedge clk);
    check("R3 stream end", {15'd0, respValid}, 16'h0000);
    check("R3 dropped lock", {15'd0, statusWord[15]}, 16'h0000);

    // R9 event flags
    @(negedge clk);
    evResync = 1'b1; evCrcErr = 1'b1; evRegCrc = 1'b1;
    @(negedge clk);
    evResync = 1'b0; evCrcErr = 1'b0; evRegCrc = 1'b0;
    check("R9 flags set", statusWord, 16'h7540);

    // R2 NULL returns status and clears
    sendWord(16'h0000);
    check("R2 null response", respWord, 16'h7540);
    check("R2 flags cleared", statusWord, 16'h0500);

    // R10 memory fault level re-sets after clear
    @(negedge clk);
    memFault = 1'b1;
    @(negedge clk);
    check("R10 fault set", statusWord, 16'h0580);
    sendWord(16'h0000);
    check("R10 persists", statusWord, 16'h0580);
    memFault = 1'b0;
    sendWord(16'h0000);
    check("R10 cleared", statusWord, 16'h0500);
    evSupply = 1'b1;
    @(negedge clk);
    evSupply = 1'b0;
    check("R9 supply flag", statusWord, 16'h0540);

    // R9 event coinciding with clear wins
    @(negedge clk);
    wordValid = 1'b1; word = 16'h0000; evResync = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; evResync = 1'b0;
    check("R9 event beats clear", statusWord, 16'h4500);
    sendWord(16'h0000);

    // R4 read covering status clears
    @(negedge clk);
    evCrcErr = 1'b1;
    @(negedge clk);
    evCrcErr = 1'b0;
    sendWord(mkCmd(3'b101, 6'h00, 7'd1));
    @(negedge clk);
    check("R4 first word", respWord, 16'h2200);
    @(negedge clk);
    check("R4 status word", respWord, 16'h1500);
    @(negedge clk);
    check("R4 cleared", statusWord, 16'h0500);

    // R7 and R8 lock behaviour
    sendWord(16'h0555);
    check("R7 lock bit", statusWord, 16'h8500);
    sendWord(mkCmd(3'b011, 6'h02, 7'd0));
    sendWord(16'h0022);
    sendWord(16'h0011);
    @(negedge clk);
    check("R8 mode frozen", modeWord, 16'h0510);
    check("R8 no standby", 16'(sbyCnt), 16'd0);
    check("R8 no reset", 16'(rstCnt), 16'd0);
    readOne(6'h02, v, vld);
    check("R8 read blocked", {15'd0, vld}, 16'h0000);
    readOne(6'h01, v, vld);
    check("R8 status read allowed", v, 16'h8500);
    sendWord(16'h0655);
    check("R7 unlock", statusWord, 16'h0500);

    // R11 and R14 reset flag and mirrors
    sendWord(mkCmd(3'b011, 6'h03, 7'd0));
    sendWord(16'h0000);
    check("R11 other write keeps flag", statusWord, 16'h0500);
    sendWord(mkCmd(3'b011, 6'h02, 7'd0));
    sendWord(16'h0B10);
    check("R14 mirror and R11 clear", statusWord, 16'h0B00);
    sendWord(mkCmd(3'b011, 6'h02, 7'd0));
    sendWord(16'h0410);
    check("R11 writing one keeps clear", statusWord, 16'h0000);

    // R5 multi-word write
    sendWord(mkCmd(3'b011, 6'h0A, 7'd1));
    sendWord(16'h1111);
    sendWord(16'h2222);
    check("R5 first word", chanFlat[31:16], 16'h1111);
    check("R5 second word masked", chanFlat[47:32], 16'h2200);

    // R12 soft reset
    sendWord(16'h0011);
    @(negedge clk);
    check("R12 pulse", 16'(rstCnt), 16'd1);
    check("R12 status", statusWord, 16'h0540);
    check("R12 mode", modeWord, 16'h0510);
    check("R12 clock", clockWord, 16'h030E);
    check("R12 channel", chanFlat[31:16], 16'h0000);

    // R13 standby and wakeup
    sendWord(16'h0022);
    @(negedge clk);
    check("R13 standby", 16'(sbyCnt), 16'd1);
    sendWord(16'h0033);
    @(negedge clk);
    check("R13 wakeup", 16'(wakCnt), 16'd1);
    check("R13 standby once", 16'(sbyCnt), 16'd1);

    // R5 and R6 table walk
    for (int i = 0; i < 14; i++) begin
      sendWord(mkCmd(3'b011, VEC[i][37:32], 7'd0));
      sendWord(VEC[i][31:16]);
      readOne(VEC[i][37:32], v, vld);
      check($sformatf("R6 R5 addr %h", VEC[i][37:32]), v, VEC[i][15:0]);
    end

    report();
  end
endmodule